// File: doc/BRIEF.md
# Segment Address Unit with Upper Address-Line Gate

This block turns a segment select and a 16-bit offset into a 24-bit physical address. It keeps four hidden segment caches, and the address is always formed from them. Each cache holds a 24-bit base, an 8-bit rights byte and a 16-bit limit. Two update paths feed the caches. A real-mode selector load rebuilds a cache from a 16-bit selector, so the base always lands in the lowest megabyte. A state-restore port writes any base, rights byte and limit in either mode, which is how a segment can sit above 1 MB while the processor stays in real mode.

Each access is checked against the cache limit and the write rights, and faults are reported. An address-line gate, controlled by software and readable by it, clears the top four physical address bits while it is disabled. The gate acts in both real and protected mode. Protected-mode descriptor table walks and the memory bus are outside this block.

Top module: `seg_addr_unit`

## Requirements
- R1: After reset every cache holds base 0x000000, limit 0xFFFF and rights 0x93, the gate is disabled (`gate_state`=0), and `acc_strobe`, `limit_fault` and `prot_fault` are low.
- R2: Segment codes are ES=0, CS=1, SS=2, DS=3. A request sampled on a clock edge drives `phys_addr` = (base + offset) mod 2^24 and its result flags on that same edge, so they are visible one cycle after the request. A carry out of bit 23 is dropped.
- R3: When `prot_mode`=0, a selector load sets the chosen cache base to {4'h0, selector, 4'h0} and its limit to 0xFFFF. The rights byte is left unchanged. Requests from the next cycle onwards see the new values.
- R4: A selector load while `prot_mode`=1 changes no cache.
- R5: A restore write loads base, rights and limit in either mode. If a restore write and a selector load target the same segment in the same cycle, the restore write wins.
- R6: While the gate is disabled, `phys_addr[23:20]` is zero in both modes. While it is enabled, all 24 bits pass; for example, selector 0xFFFF with offset 0xFFFF gives 0x10FFEF.
- R7: `gate_set_en` loads `gate_set_val` into the gate, and `gate_state` shows the value held.
- R8: An offset greater than the limit raises `limit_fault` and suppresses `acc_strobe`. An offset equal to the limit is allowed.
- R9: A write raises `prot_fault` and suppresses `acc_strobe` when rights bit 3 (code segment) is 1, or when rights bit 1 (writable) is 0. Reads never raise `prot_fault`.
- R10: In a cycle after which no request was sampled, `acc_strobe`, `limit_fault` and `prot_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| sel_ld_en | input | 1 | Real-mode selector load strobe |
| sel_ld_seg | input | 2 | Segment targeted by the selector load |
| sel_ld_val | input | 16 | Selector value |
| restore_en | input | 1 | Restore write strobe |
| restore_seg | input | 2 | Segment targeted by the restore write |
| restore_base | input | 24 | Base to restore |
| restore_rights | input | 8 | Rights byte to restore |
| restore_limit | input | 16 | Limit to restore |
| gate_set_en | input | 1 | Gate update strobe |
| gate_set_val | input | 1 | New gate value (1 = upper lines enabled) |
| gate_state | output | 1 | Current gate value |
| acc_req | input | 1 | Access request |
| acc_seg | input | 2 | Segment of the access |
| acc_offset | input | 16 | Offset of the access |
| acc_write | input | 1 | 1 = write access |
| acc_strobe | output | 1 | Access granted, address valid |
| phys_addr | output | 24 | Physical address |
| limit_fault | output | 1 | Offset above limit |
| prot_fault | output | 1 | Write not permitted |

## Verification
The hardest state to reach from the ports is a real-mode segment whose base lies above 1 MB. It has to be set up through a restore write and must then survive a selector load issued in protected mode. The bench builds exactly that sequence, then toggles the gate and the mode, and checks that the masked and unmasked addresses differ only in bits 23:20. It also creates a base near the top of the space so that base plus offset carries out of bit 23. A selector load and a restore write are issued to one segment in the same cycle to show which one wins.

// File: rtl/seg_addr_pkg.sv
// Shared widths, cache record type and reset constants for the segment
// address unit. Assumes a 24-bit physical space and 16-bit offsets.
package seg_addr_pkg;
    localparam int PADDR_W  = 24;
    localparam int OFS_W    = 16;
    localparam int NSEG     = 4;
    localparam int SEGIDX_W = $clog2(NSEG);
    localparam int GATED_W  = 4;
    localparam int SEL_SH   = 4;
    localparam int HI_PAD   = PADDR_W - OFS_W - SEL_SH;

    localparam logic [7:0]       RIGHTS_RESET = 8'h93;
    localparam logic [OFS_W-1:0] LIMIT_REAL   = '1;

    localparam int RIGHT_WR_BIT   = 1;
    localparam int RIGHT_CODE_BIT = 3;

    typedef struct packed {
        logic [PADDR_W-1:0] base;
        logic [7:0]         rights;
        logic [OFS_W-1:0]   limit;
    } seg_cache_t;
endpackage

// File: rtl/seg_cache_bank.sv
// Four hidden segment caches. A restore write loads a whole cache in any
// mode and takes priority. A real-mode selector load rebuilds base and
// limit and keeps the rights byte. Assumes one update per segment per cycle.
module seg_cache_bank
    import seg_addr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prot_mode,
    input  logic                sel_ld_en,
    input  logic [SEGIDX_W-1:0] sel_ld_seg,
    input  logic [OFS_W-1:0]    sel_ld_val,
    input  logic                restore_en,
    input  logic [SEGIDX_W-1:0] restore_seg,
    input  seg_cache_t          restore_rec,
    output seg_cache_t          caches [NSEG]
);
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        // Per-segment cache update with restore-write priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                caches[g].base   <= '0;
                caches[g].rights <= RIGHTS_RESET;
                caches[g].limit  <= LIMIT_REAL;
            end else if (restore_en && restore_seg == SEGIDX_W'(g)) begin
                caches[g] <= restore_rec;
            end else if (sel_ld_en && !prot_mode && sel_ld_seg == SEGIDX_W'(g)) begin
                caches[g].base  <= {{HI_PAD{1'b0}}, sel_ld_val, {SEL_SH{1'b0}}};
                caches[g].limit <= LIMIT_REAL;
            end
        end
    end
endmodule

// File: rtl/seg_line_gate.sv
// Holds the upper-address-line gate bit. It is disabled at reset and
// updated only by an explicit set strobe.
module seg_line_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic set_val,
    output logic enabled
);
    // Gate register.
    always_ff @(posedge clk) begin
        if (!rst_n)      enabled <= 1'b0;
        else if (set_en) enabled <= set_val;
    end
endmodule

// File: rtl/seg_addr_gen.sv
// Registered address former: base plus offset modulo the physical space,
// upper lines masked while the gate is disabled, and limit and rights
// checks. Assumes the inputs are the selected cache fields for this cycle.
module seg_addr_gen
    import seg_addr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               wr,
    input  logic [OFS_W-1:0]   offset,
    input  logic [PADDR_W-1:0] base,
    input  logic [OFS_W-1:0]   limit,
    input  logic               seg_writable,
    input  logic               seg_is_code,
    input  logic               gate_on,
    output logic               strobe,
    output logic [PADDR_W-1:0] addr,
    output logic               lim_flt,
    output logic               prot_flt
);
    logic [PADDR_W-1:0] sum;
    logic [PADDR_W-1:0] masked;
    logic               over;
    logic               denied;

    // Combinational sum, gate mask and checks.
    always_comb begin
        sum    = base + PADDR_W'(offset);
        masked = gate_on ? sum : {{GATED_W{1'b0}}, sum[PADDR_W-GATED_W-1:0]};
        over   = offset > limit;
        denied = wr && (seg_is_code || !seg_writable);
    end

    // Output register for the address and the result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe   <= 1'b0;
            addr     <= '0;
            lim_flt  <= 1'b0;
            prot_flt <= 1'b0;
        end else begin
            addr     <= masked;
            strobe   <= req && !over && !denied;
            lim_flt  <= req && over;
            prot_flt <= req && denied;
        end
    end
endmodule

// File: rtl/seg_addr_unit.sv
// Top level: the cache bank, the line gate and the address former.
// Addresses come only from the hidden caches. Assumes the segment select
// and the offset are stable for the cycle in which acc_req is high.
module seg_addr_unit
    import seg_addr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prot_mode,
    input  logic                sel_ld_en,
    input  logic [SEGIDX_W-1:0] sel_ld_seg,
    input  logic [OFS_W-1:0]    sel_ld_val,
    input  logic                restore_en,
    input  logic [SEGIDX_W-1:0] restore_seg,
    input  logic [PADDR_W-1:0]  restore_base,
    input  logic [7:0]          restore_rights,
    input  logic [OFS_W-1:0]    restore_limit,
    input  logic                gate_set_en,
    input  logic                gate_set_val,
    output logic                gate_state,
    input  logic                acc_req,
    input  logic [SEGIDX_W-1:0] acc_seg,
    input  logic [OFS_W-1:0]    acc_offset,
    input  logic                acc_write,
    output logic                acc_strobe,
    output logic [PADDR_W-1:0]  phys_addr,
    output logic                limit_fault,
    output logic                prot_fault
);
    seg_cache_t caches [NSEG];
    seg_cache_t cur;
    seg_cache_t rest_rec;
    logic       unused_rights;

    // Pack the restore fields into a record and select the active cache.
    always_comb begin
        rest_rec.base   = restore_base;
        rest_rec.rights = restore_rights;
        rest_rec.limit  = restore_limit;
        cur             = caches[acc_seg];
    end

    assign unused_rights = ^{cur.rights[7:4], cur.rights[2], cur.rights[0]};

    seg_cache_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .prot_mode   (prot_mode),
        .sel_ld_en   (sel_ld_en),
        .sel_ld_seg  (sel_ld_seg),
        .sel_ld_val  (sel_ld_val),
        .restore_en  (restore_en),
        .restore_seg (restore_seg),
        .restore_rec (rest_rec),
        .caches      (caches)
    );

    seg_line_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (gate_set_en),
        .set_val (gate_set_val),
        .enabled (gate_state)
    );

    seg_addr_gen u_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (acc_req),
        .wr           (acc_write),
        .offset       (acc_offset),
        .base         (cur.base),
        .limit        (cur.limit),
        .seg_writable (cur.rights[RIGHT_WR_BIT]),
        .seg_is_code  (cur.rights[RIGHT_CODE_BIT]),
        .gate_on      (gate_state),
        .strobe       (acc_strobe),
        .addr         (phys_addr),
        .lim_flt      (limit_fault),
        .prot_flt     (prot_fault)
    );
endmodule

// File: rtl/seg_addr_unit_chk.sv
// Port-level checker for seg_addr_unit, attached with bind.
module seg_addr_unit_chk
    import seg_addr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               gate_set_en,
    input logic               gate_set_val,
    input logic               gate_state,
    input logic               acc_req,
    input logic               acc_strobe,
    input logic [PADDR_W-1:0] phys_addr,
    input logic               limit_fault,
    input logic               prot_fault
);
    // R8 and R9: a granted access never carries a fault.
    p_grant_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_strobe |-> (!limit_fault && !prot_fault));

    // R6: a request made with the gate disabled yields no upper address bits.
    p_gate_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !gate_state) |=> (phys_addr[PADDR_W-1 -: GATED_W] == '0));

    // R7: the gate follows its set strobe.
    p_gate_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gate_set_en |=> (gate_state == $past(gate_set_val)));

    // R7: without a set strobe the gate holds its value.
    p_gate_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_set_en |=> $stable(gate_state));

    // R10: no request, no result flags.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> (!acc_strobe && !limit_fault && !prot_fault));
endmodule

bind seg_addr_unit seg_addr_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_set_en  (gate_set_en),
    .gate_set_val (gate_set_val),
    .gate_state   (gate_state),
    .acc_req      (acc_req),
    .acc_strobe   (acc_strobe),
    .phys_addr    (phys_addr),
    .limit_fault  (limit_fault),
    .prot_fault   (prot_fault)
);

// File: tb/seg_addr_unit_tb.sv
`timescale 1ns/1ps
module seg_addr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_mode = 1'b0;
    logic        sel_ld_en = 1'b0;
    logic [1:0]  sel_ld_seg = '0;
    logic [15:0] sel_ld_val = '0;
    logic        restore_en = 1'b0;
    logic [1:0]  restore_seg = '0;
    logic [23:0] restore_base = '0;
    logic [7:0]  restore_rights = '0;
    logic [15:0] restore_limit = '0;
    logic        gate_set_en = 1'b0;
    logic        gate_set_val = 1'b0;
    logic        gate_state;
    logic        acc_req = 1'b0;
    logic [1:0]  acc_seg = '0;
    logic [15:0] acc_offset = '0;
    logic        acc_write = 1'b0;
    logic        acc_strobe;
    logic [23:0] phys_addr;
    logic        limit_fault;
    logic        prot_fault;

    localparam logic [1:0] S_ES = 2'd0, S_CS = 2'd1, S_SS = 2'd2, S_DS = 2'd3;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    seg_addr_unit u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One access; outputs are sampled at the following falling edge.
    task automatic access(input logic [1:0] s, input logic [15:0] o, input logic w);
        @(negedge clk);
        acc_req = 1'b1; acc_seg = s; acc_offset = o; acc_write = w;
        @(negedge clk);
        acc_req = 1'b0; acc_write = 1'b0;
    endtask

    // Access and check address, strobe and both faults.
    task automatic expect_acc(input string tag, input logic [1:0] s, input logic [15:0] o,
                              input logic w, input logic [23:0] ea, input logic es,
                              input logic el, input logic ep);
        access(s, o, w);
        if (es) chk({tag, " addr"}, 32'(phys_addr), 32'(ea));
        chk({tag, " strobe"}, 32'(acc_strobe), 32'(es));
        chk({tag, " limit_fault"}, 32'(limit_fault), 32'(el));
        chk({tag, " prot_fault"}, 32'(prot_fault), 32'(ep));
    endtask

    task automatic sel_load(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        sel_ld_en = 1'b1; sel_ld_seg = s; sel_ld_val = v;
        @(negedge clk);
        sel_ld_en = 1'b0;
    endtask

    task automatic restore(input logic [1:0] s, input logic [23:0] b,
                           input logic [7:0] r, input logic [15:0] l);
        @(negedge clk);
        restore_en = 1'b1; restore_seg = s; restore_base = b;
        restore_rights = r; restore_limit = l;
        @(negedge clk);
        restore_en = 1'b0;
    endtask

    task automatic set_gate(input logic v);
        @(negedge clk);
        gate_set_en = 1'b1; gate_set_val = v;
        @(negedge clk);
        gate_set_en = 1'b0;
        chk("R7 gate_state", 32'(gate_state), 32'(v));
    endtask

    task automatic t_reset;
        chk("R1 gate off", 32'(gate_state), 32'd0);
        chk("R1 strobe low", 32'(acc_strobe), 32'd0);
        expect_acc("R1 ES base 0", S_ES, 16'h1234, 1'b0, 24'h001234, 1, 0, 0);
        expect_acc("R1 DS limit FFFF", S_DS, 16'hFFFF, 1'b1, 24'h00FFFF, 1, 0, 0);
        @(negedge clk);
        chk("R10 idle strobe", 32'(acc_strobe), 32'd0);
        chk("R10 idle faults", 32'({limit_fault, prot_fault}), 32'd0);
    endtask

    task automatic t_selector;
        sel_load(S_CS, 16'h1234);
        expect_acc("R3 CS rebuild", S_CS, 16'h0010, 1'b0, 24'h012350, 1, 0, 0);
        expect_acc("R2 CS unaffected ES", S_ES, 16'h0010, 1'b0, 24'h000010, 1, 0, 0);
    endtask

    task automatic t_gate;
        set_gate(1'b1);
        sel_load(S_DS, 16'hFFFF);
        expect_acc("R6 gate on top", S_DS, 16'hFFFF, 1'b0, 24'h10FFEF, 1, 0, 0);
        set_gate(1'b0);
        expect_acc("R6 gate off wrap", S_DS, 16'hFFFF, 1'b0, 24'h00FFEF, 1, 0, 0);
    endtask

    task automatic t_restore_limit;
        set_gate(1'b1);
        restore(S_SS, 24'h123450, 8'h93, 16'h00FF);
        expect_acc("R5 SS high base", S_SS, 16'h0010, 1'b0, 24'h123460, 1, 0, 0);
        expect_acc("R8 at limit", S_SS, 16'h00FF, 1'b0, 24'h12354F, 1, 0, 0);
        expect_acc("R8 over limit", S_SS, 16'h0100, 1'b0, 24'h0, 0, 1, 0);
    endtask

    task automatic t_prot_mode;
        @(negedge clk) prot_mode = 1'b1;
        sel_load(S_SS, 16'h0000);
        expect_acc("R4 load ignored", S_SS, 16'h0000, 1'b0, 24'h123450, 1, 0, 0);
        expect_acc("R4 limit kept", S_SS, 16'h0100, 1'b0, 24'h0, 0, 1, 0);
        set_gate(1'b0);
        expect_acc("R6 gate off prot", S_SS, 16'h0000, 1'b0, 24'h023450, 1, 0, 0);
        restore(S_CS, 24'hABCDE0, 8'h93, 16'hFFFF);
        set_gate(1'b1);
        expect_acc("R5 restore in prot", S_CS, 16'h0001, 1'b0, 24'hABCDE1, 1, 0, 0);
        @(negedge clk) prot_mode = 1'b0;
    endtask

    task automatic t_carry;
        restore(S_ES, 24'hFFFFF0, 8'h93, 16'hFFFF);
        expect_acc("R2 carry dropped", S_ES, 16'h0020, 1'b0, 24'h000010, 1, 0, 0);
    endtask

    task automatic t_conflict;
        @(negedge clk);
        sel_ld_en = 1'b1; sel_ld_seg = S_DS; sel_ld_val = 16'h0001;
        restore_en = 1'b1; restore_seg = S_DS; restore_base = 24'h200000;
        restore_rights = 8'h93; restore_limit = 16'hFFFF;
        @(negedge clk);
        sel_ld_en = 1'b0; restore_en = 1'b0;
        expect_acc("R5 restore wins", S_DS, 16'h0000, 1'b0, 24'h200000, 1, 0, 0);
    endtask

    task automatic t_rights;
        restore(S_ES, 24'h000100, 8'h90, 16'hFFFF);
        expect_acc("R9 ro write", S_ES, 16'h0000, 1'b1, 24'h0, 0, 0, 1);
        expect_acc("R9 ro read", S_ES, 16'h0000, 1'b0, 24'h000100, 1, 0, 0);
        sel_load(S_ES, 16'h0010);
        expect_acc("R3 rights kept", S_ES, 16'h0000, 1'b1, 24'h0, 0, 0, 1);
        restore(S_CS, 24'h000200, 8'h9A, 16'hFFFF);
        expect_acc("R9 code write", S_CS, 16'h0000, 1'b1, 24'h0, 0, 0, 1);
        expect_acc("R9 code read", S_CS, 16'h0004, 1'b0, 24'h000204, 1, 0, 0);
    endtask

    task automatic t_sel_limit;
        sel_load(S_SS, 16'h0800);
        expect_acc("R3 limit restored", S_SS, 16'h1000, 1'b0, 24'h009000, 1, 0, 0);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_selector();
        t_gate();
        t_restore_limit();
        t_prot_mode();
        t_carry();
        t_conflict();
        t_rights();
        t_sel_limit();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule